// File: doc/BRIEF.md
# Banked GPIO and Pin-Function Controller

This block gives software control of up to a parameterised number of general-purpose pins through a plain 32-bit register port. Pins are grouped into banks of 32. Every register kind has one word for each bank. Each pin has an output latch, a drive-enable bit, a synchronised input, a sticky interrupt flag with an enable, a detection-mode bit and a 2-bit function selector. The selector is exported so that an external mux can route the pin to a peripheral.

Software changes the output latch only through write-one-to-set and write-one-to-clear words. Several agents can therefore touch different pins of a bank without a read-modify-write race. Interrupt flags are set by hardware and cleared by writing ones. A read-only identity word per bank shows the pins that are pending and enabled. A single line reports the OR of every bank's identity word.

Top module: `gpx_ctrl`

## Requirements
- R1: With NB = 1 + (NPINS-1)/32 banks, register kind k of bank b sits at byte address 4*(k*NB + b). The kind codes are: 0 set, 1 clear, 2 output value, 3 input, 4 drive enable, 5 status, 6 interrupt enable, 7 identity, 8 function bit 0, 9 function bit 1, 10 detection mode. Pin n is bit n mod 32 of bank n/32. Any address with a kind of 11 or more reads 0.
- R2: Writing the set word makes every pin whose data bit is 1 drive high on the next cycle. Zero bits leave the latch as it was. The set and clear words read as 0.
- R3: Writing the clear word makes every pin whose data bit is 1 drive low on the next cycle. Zero bits leave the latch as it was.
- R4: The output-value word reads the latch, which also appears on pin_out. The drive-enable word is read/write and appears on pin_oe, where 1 means drive. The output latch, the drive enables and the function codes change only on a register write.
- R5: The input word reads each pin through a two-flop synchroniser. A change at pin_in becomes visible after the second rising clock edge and not after the first.
- R6: With the mode bit at 0 (edge), any change of the synchronised input, rising or falling, sets the pin's status bit. A steady input sets nothing more.
- R7: With the mode bit at 1 (level), the status bit is set on every cycle while the synchronised input is high. It can therefore only be cleared once the input is low.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A detection event in the same cycle as the clear wins.
- R9: The identity word equals status AND enable. irq is the OR of all identity bits. A pin with a clear enable bit keeps its status flag but does not raise irq.
- R10: pin_func[2n+1:2n] = {function bit 1 word bit, function bit 0 word bit} for pin n. Code 0 means plain GPIO.
- R11: Bits for pin numbers at or beyond NPINS read as 0 in every word and ignore writes.
- R12: Reset clears every latch, enable, flag, mode and function bit, and drives irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Output latch per pin |
| pin_oe | output | NPINS | Drive enable per pin |
| pin_func | output | 2*NPINS | Function code per pin, two bits each |
| irq | output | 1 | Aggregated interrupt |

## Verification
The bound checker watches, on every cycle, that set and clear writes reach the bank-0 pins on the next cycle. It also checks that the latch, the drive enables and the function codes hold when no write occurs, that the bank-0 identity word is zero whenever irq is low, and that unmapped addresses read zero. The bench alone can show the synchroniser latency, the difference between edge and level detection, the race between a clear and a new event, the masking of pins past NPINS, and reset of a busy register set. It checks these with directed pin waveforms after a randomised register workload.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int BANK_W = 32;
    localparam int NKIND  = 11;

    typedef enum logic [3:0] {
        K_SET  = 4'd0,
        K_CLR  = 4'd1,
        K_OUT  = 4'd2,
        K_IN   = 4'd3,
        K_OE   = 4'd4,
        K_ST   = 4'd5,
        K_IE   = 4'd6,
        K_ID   = 4'd7,
        K_ALT0 = 4'd8,
        K_ALT1 = 4'd9,
        K_MODE = 4'd10
    } kind_e;

    // read-back view of one bank
    typedef struct packed {
        logic [BANK_W-1:0] mode;
        logic [BANK_W-1:0] alt1;
        logic [BANK_W-1:0] alt0;
        logic [BANK_W-1:0] ident;
        logic [BANK_W-1:0] ie;
        logic [BANK_W-1:0] st;
        logic [BANK_W-1:0] oe;
        logic [BANK_W-1:0] din;
        logic [BANK_W-1:0] out;
    } bank_view_t;

    function automatic int bank_count(int npins);
        return 1 + (npins - 1) / BANK_W;
    endfunction

    // bits of bank b that correspond to real pins
    function automatic logic [BANK_W-1:0] bank_mask(int npins, int b);
        int left;
        left = npins - BANK_W * b;
        if (left >= BANK_W)
            return '1;
        else if (left <= 0)
            return '0;
        else
            return (32'd1 << left) - 32'd1;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++)
                stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++)
                stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
#(
    parameter logic [BANK_W-1:0] VALID       = '1,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NKIND-1:0]  wr_kind,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] raw_in,
    output bank_view_t        view
);
    logic [BANK_W-1:0] din_s, din_d;
    logic [BANK_W-1:0] out_q, oe_q, st_q, ie_q, a0_q, a1_q, mode_q;
    logic [BANK_W-1:0] wmask, evt, st_clr;

    gpx_sync #(.W(BANK_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in & VALID),
        .q   (din_s)
    );

    assign wmask  = wdata & VALID;
    // level pins fire while high, edge pins fire on any change
    assign evt    = ((mode_q & din_s) | (~mode_q & (din_s ^ din_d))) & VALID;
    assign st_clr = wr_kind[K_ST] ? wmask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            din_d  <= '0;
            out_q  <= '0;
            oe_q   <= '0;
            st_q   <= '0;
            ie_q   <= '0;
            a0_q   <= '0;
            a1_q   <= '0;
            mode_q <= '0;
        end else begin
            din_d <= din_s;
            if (wr_kind[K_SET])
                out_q <= out_q | wmask;
            else if (wr_kind[K_CLR])
                out_q <= out_q & ~wmask;
            if (wr_kind[K_OE])   oe_q   <= wmask;
            if (wr_kind[K_IE])   ie_q   <= wmask;
            if (wr_kind[K_ALT0]) a0_q   <= wmask;
            if (wr_kind[K_ALT1]) a1_q   <= wmask;
            if (wr_kind[K_MODE]) mode_q <= wmask;
            st_q <= (st_q & ~st_clr) | evt;
        end
    end

    always_comb begin
        view.out   = out_q;
        view.din   = din_s;
        view.oe    = oe_q;
        view.st    = st_q;
        view.ie    = ie_q;
        view.ident = st_q & ie_q;
        view.alt0  = a0_q;
        view.alt1  = a1_q;
        view.mode  = mode_q;
    end
endmodule

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
    import gpx_pkg::*;
#(
    parameter int NPINS       = 64,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NPINS-1:0]    pin_in,
    output logic [NPINS-1:0]    pin_out,
    output logic [NPINS-1:0]    pin_oe,
    output logic [2*NPINS-1:0]  pin_func,
    output logic                irq
);
    localparam int NB   = bank_count(NPINS);
    localparam int WW   = ADDR_W - 2;
    localparam int PADW = BANK_W * NB;

    logic [WW-1:0]   word_idx, kind_idx, bank_idx;
    logic [PADW-1:0] in_pad, out_pad, oe_pad, a0_pad, a1_pad, id_pad;
    bank_view_t      views [NB];
    bank_view_t      sel;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign kind_idx = word_idx / WW'(NB);
    assign bank_idx = word_idx % WW'(NB);
    assign in_pad   = PADW'(pin_in);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [NKIND-1:0] we_k;
        always_comb begin
            for (int k = 0; k < NKIND; k++)
                we_k[k] = bus_we && (bank_idx == WW'(b)) && (kind_idx == WW'(k));
        end

        gpx_bank #(
            .VALID       (bank_mask(NPINS, b)),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_kind (we_k),
            .wdata   (bus_wdata),
            .raw_in  (in_pad[BANK_W*b +: BANK_W]),
            .view    (views[b])
        );

        assign out_pad[BANK_W*b +: BANK_W] = views[b].out;
        assign oe_pad [BANK_W*b +: BANK_W] = views[b].oe;
        assign a0_pad [BANK_W*b +: BANK_W] = views[b].alt0;
        assign a1_pad [BANK_W*b +: BANK_W] = views[b].alt1;
        assign id_pad [BANK_W*b +: BANK_W] = views[b].ident;
    end

    assign pin_out = out_pad[NPINS-1:0];
    assign pin_oe  = oe_pad[NPINS-1:0];
    assign irq     = |id_pad;

    for (genvar n = 0; n < NPINS; n++) begin : g_func
        assign pin_func[2*n +: 2] = {a1_pad[n], a0_pad[n]};
    end

    always_comb begin
        sel = '0;
        for (int b = 0; b < NB; b++)
            if (bank_idx == WW'(b))
                sel = views[b];
    end

    always_comb begin
        case (kind_idx)
            WW'(K_OUT):  bus_rdata = sel.out;
            WW'(K_IN):   bus_rdata = sel.din;
            WW'(K_OE):   bus_rdata = sel.oe;
            WW'(K_ST):   bus_rdata = sel.st;
            WW'(K_IE):   bus_rdata = sel.ie;
            WW'(K_ID):   bus_rdata = sel.ident;
            WW'(K_ALT0): bus_rdata = sel.alt0;
            WW'(K_ALT1): bus_rdata = sel.alt1;
            WW'(K_MODE): bus_rdata = sel.mode;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker
    import gpx_pkg::*;
#(
    parameter int NPINS       = 64,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [NPINS-1:0]    pin_in,
    input logic [NPINS-1:0]    pin_out,
    input logic [NPINS-1:0]    pin_oe,
    input logic [2*NPINS-1:0]  pin_func,
    input logic                irq
);
    localparam int NB   = bank_count(NPINS);
    localparam int PADW = BANK_W * NB;
    localparam logic [31:0] MASK0 = bank_mask(NPINS, 0);
    localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(4 * NB);
    localparam logic [ADDR_W-1:0] A_ID0  = ADDR_W'(4 * 7 * NB);
    localparam int A_LIMIT = 4 * NKIND * NB;

    logic [PADW-1:0] po_pad;
    assign po_pad = PADW'(pin_out);

    p_set_high_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_SET0) |=>
        ((po_pad[31:0] & $past(bus_wdata & MASK0)) == $past(bus_wdata & MASK0)));

    p_clr_low_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CLR0) |=>
        ((po_pad[31:0] & $past(bus_wdata & MASK0)) == 32'd0));

    p_hold_out_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));

    p_hold_func_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(pin_func));

    p_ident_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_ID0 && !irq) |-> (bus_rdata == 32'd0));

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) >= A_LIMIT) |-> (bus_rdata == 32'd0));
endmodule

bind gpx_ctrl gpx_checker #(
    .NPINS       (NPINS),
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/sim_gpx_ctrl.sv
module sim_gpx_ctrl;
    localparam int NP = 40;
    localparam int AW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pin_in = '0;
    logic [NP-1:0]   pin_out, pin_oe;
    logic [2*NP-1:0] pin_func;
    logic            irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] m_out [2];
    logic [31:0] m_oe  [2];
    logic [31:0] m_ie  [2];
    logic [31:0] m_a0  [2];
    logic [31:0] m_a1  [2];
    logic [31:0] m_md  [2];
    logic [31:0] mk    [2];

    gpx_ctrl #(.NPINS(NP), .ADDR_W(AW)) u0 (
        .clk, .rst, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .pin_in, .pin_out, .pin_oe, .pin_func, .irq
    );

    always #5 clk = ~clk;

    function automatic logic [AW-1:0] ad(int k, int b);
        return AW'(4 * (2 * k + b));
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_clear();
        for (int b = 0; b < 2; b++) begin
            m_out[b] = '0; m_oe[b] = '0; m_ie[b] = '0;
            m_a0[b] = '0; m_a1[b] = '0; m_md[b] = '0;
        end
    endtask

    task automatic model_wr(int k, int b, logic [31:0] d);
        logic [31:0] v;
        v = d & mk[b];
        case (k)
            0:  m_out[b] = m_out[b] | v;
            1:  m_out[b] = m_out[b] & ~v;
            4:  m_oe[b]  = v;
            6:  m_ie[b]  = v;
            8:  m_a0[b]  = v;
            9:  m_a1[b]  = v;
            10: m_md[b]  = v;
            default: ;
        endcase
    endtask

    function automatic logic [31:0] model_rd(int k, int b);
        case (k)
            2:  return m_out[b];
            4:  return m_oe[b];
            6:  return m_ie[b];
            8:  return m_a0[b];
            9:  return m_a1[b];
            10: return m_md[b];
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [2*NP-1:0] model_func();
        logic [2*NP-1:0] f;
        for (int n = 0; n < NP; n++)
            f[2*n +: 2] = {m_a1[n/32][n%32], m_a0[n/32][n%32]};
        return f;
    endfunction

    task automatic check_reset_state(string tag);
        logic [31:0] d;
        for (int k = 0; k < 11; k++)
            for (int b = 0; b < 2; b++) begin
                rd(ad(k, b), d);
                check({tag, " R12 reset word"}, d, 0);
            end
        check({tag, " R12 pins"}, {pin_out, pin_oe, pin_func, irq}, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int kinds [7] = '{0, 1, 4, 6, 8, 9, 10};
        void'($urandom(32'd4242));
        mk[0] = 32'hFFFF_FFFF;
        mk[1] = 32'h0000_00FF;
        model_clear();
        tick(3);
        rst = 1'b0;
        check_reset_state("first");

        // randomised register workload, inputs held low
        for (int it = 0; it < 400; it++) begin
            int k, b, rk, rb;
            logic [31:0] v;
            k = kinds[$urandom_range(0, 6)];
            b = int'($urandom_range(0, 1));
            v = $urandom;
            wr(ad(k, b), v);
            model_wr(k, b, v);
            rk = kinds[$urandom_range(0, 6)];
            if ($urandom_range(0, 3) == 0) rk = 2;
            rb = int'($urandom_range(0, 1));
            rd(ad(rk, rb), d);
            check("R2 R3 R4 R11 readback", d, model_rd(rk, rb));
            if (it % 8 == 0) begin
                check("R4 pin_out", pin_out, {m_out[1][7:0], m_out[0]});
                check("R4 pin_oe", pin_oe, {m_oe[1][7:0], m_oe[0]});
                check("R10 pin_func", pin_func, model_func());
            end
        end

        // reset from a busy state
        @(negedge clk); rst = 1'b1;
        tick(2);
        @(negedge clk); rst = 1'b0;
        model_clear();
        check_reset_state("second");

        // R5: synchroniser latency
        @(negedge clk); pin_in[3] = 1'b1;
        rd(ad(3, 0), d);
        check("R5 one edge", d, 32'h0);
        rd(ad(3, 0), d);
        check("R5 two edges", d, 32'h8);

        // R6 edge detection, R9 masking and identity
        tick(3);
        rd(ad(5, 0), d);
        check("R6 rise sets status", d, 32'h8);
        rd(ad(7, 0), d);
        check("R9 masked ident", d, 32'h0);
        check("R9 masked irq", irq, 0);
        wr(ad(6, 0), 32'h8);
        rd(ad(7, 0), d);
        check("R9 ident after enable", d, 32'h8);
        check("R9 irq raised", irq, 1);
        wr(ad(5, 0), 32'h0);
        rd(ad(5, 0), d);
        check("R8 zero write keeps", d, 32'h8);
        wr(ad(5, 0), 32'h8);
        tick(2);
        rd(ad(5, 0), d);
        check("R6 steady input no event", d, 32'h0);
        check("R9 irq dropped", irq, 0);
        @(negedge clk); pin_in[3] = 1'b0;
        tick(4);
        rd(ad(5, 0), d);
        check("R6 fall sets status", d, 32'h8);
        wr(ad(5, 0), 32'h8);
        wr(ad(6, 0), 32'h0);

        // R7 level detection and R8 set-wins race
        wr(ad(10, 0), 32'h20);
        tick(3);
        rd(ad(5, 0), d);
        check("R7 level low quiet", d, 32'h0);
        @(negedge clk); pin_in[5] = 1'b1;
        tick(4);
        rd(ad(5, 0), d);
        check("R7 level high sets", d, 32'h20);
        wr(ad(5, 0), 32'h20);
        rd(ad(5, 0), d);
        check("R8 event beats clear", d, 32'h20);
        @(negedge clk); pin_in[5] = 1'b0;
        tick(4);
        wr(ad(5, 0), 32'h20);
        rd(ad(5, 0), d);
        check("R7 clear after low", d, 32'h0);

        // R1 second bank addressing and R9 aggregate line
        wr(ad(6, 1), 32'h2);
        @(negedge clk); pin_in[33] = 1'b1;
        tick(4);
        rd(ad(7, 1), d);
        check("R1 bank1 ident", d, 32'h2);
        check("R9 irq from bank1", irq, 1);
        rd(ad(7, 0), d);
        check("R1 bank0 ident clear", d, 32'h0);

        // R11 pins past NPINS
        wr(ad(4, 1), 32'hFFFF_FFFF);
        rd(ad(4, 1), d);
        check("R11 oe upper bits", d, 32'h0000_00FF);
        wr(ad(0, 1), 32'hFFFF_FFFF);
        rd(ad(2, 1), d);
        check("R11 out upper bits", d, 32'h0000_00FF);
        check("R2 bank1 pins high", pin_out[39:32], 8'hFF);
        wr(ad(1, 1), 32'h0000_0081);
        check("R3 bank1 pins cleared", pin_out[39:32], 8'h7E);

        // R10 function codes
        wr(ad(8, 0), 32'h0000_0180);
        wr(ad(9, 0), 32'h0000_0280);
        check("R10 pin7 code 3", pin_func[15:14], 2'd3);
        check("R10 pin8 code 1", pin_func[17:16], 2'd1);
        check("R10 pin9 code 2", pin_func[19:18], 2'd2);
        check("R10 pin6 gpio", pin_func[13:12], 2'd0);

        // R1 unmapped addresses
        rd(8'h58, d);
        check("R1 unmapped 0x58", d, 32'h0);
        rd(8'hFC, d);
        check("R1 unmapped 0xFC", d, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule